// File: doc/BRIEF.md
# Two-Agent Priority Bus Ownership Arbiter

This block decides which of two agents owns a shared request bus. One agent is symmetric: it asks for the bus by pulling its active-low request line low. The other agent has priority: it can take the bus at any moment by pulling its own active-low priority line low. The block samples that line on the rising clock edge. In the cycle after the first active sample, the block withdraws the symmetric agent's permission to start new transactions and hands ownership to the priority agent.

There is one exception. A locked sequence that the symmetric agent has already begun runs to its end, even against a priority request. The block marks a lock when the symmetric agent opens one and clears it when the sequence closes. It refuses to open a new lock while a priority request is being seen. The block also keeps a count of transactions the priority agent has issued but not yet completed. The priority agent may drop its request only once that count is zero. When the priority request goes away and the symmetric agent is still asking, ownership returns to the symmetric agent on the following cycle.

Top module: `prio_bus_arb`

## Requirements
- R1: After reset, the owner code is 0 (no owner), issue enable is 0, the lock flag is 0 and the outstanding count is 0.
- R2: With the priority line high and the symmetric request low at a rising edge, the owner code is 1 (symmetric) and issue enable is 1 in the following cycle.
- R3: When the priority line is sampled low at an edge and no lock is held, the owner code is 2 (priority) and issue enable is 0 in the following cycle.
- R4: While a lock is held, a priority request leaves the owner at 1 and issue enable at 1. On the edge that samples lock_end high, the lock clears, the owner becomes 2 and issue enable becomes 0.
- R5: A lock_start pulse while the priority request is being seen (owner 2) does not set the lock flag.
- R6: A lock_start pulse while the owner is 1 and the priority line is high sets the lock flag in the next cycle. A lock_end pulse clears it in the next cycle.
- R7: The outstanding count rises by 1 for each edge with pri_issue high and pri_done low. It falls by 1 for pri_done high and pri_issue low. It is unchanged when both are high. It saturates at 2**CNT_W-1 and at 0.
- R8: When the priority line is sampled high again with the symmetric request low, the owner is 1 and issue enable is 1 in the next cycle.
- R9: With both request lines high and no lock, the owner code is 0 and issue enable is 0 in the next cycle.
- R10: A lock_start pulse while the owner is 0 does not set the lock flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_req_n | input | 1 | Symmetric agent bus request, active low |
| pri_req_n | input | 1 | Priority agent bus request, active low |
| lock_start | input | 1 | Symmetric agent opens a locked sequence |
| lock_end | input | 1 | Locked sequence finished |
| pri_issue | input | 1 | Priority agent issued a transaction |
| pri_done | input | 1 | One priority transaction completed |
| sym_issue_en | output | 1 | Symmetric agent may start new transactions |
| owner | output | 2 | 0 none, 1 symmetric, 2 priority |
| lock_active | output | 1 | Locked sequence in progress |
| pri_outstanding | output | CNT_W | Priority transactions not yet completed |

## Verification
A wrong owner state or a stale sampled priority flag shows on sym_issue_en and owner one edge after the stimulus. The bench checks both ports in exactly that cycle. A lock flag that is set when it should not be shows as ownership staying with the symmetric agent when a later priority request arrives. A lock flag that is missed shows as lock_active staying low. An off-by-one or a wrap in the outstanding counter shows on pri_outstanding after the edge that moves it, and at both saturation limits.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic [1:0] {
      OWN_NONE = 2'b00,
      OWN_SYM  = 2'b01,
      OWN_PRI  = 2'b10
   } own_e;
endpackage

// File: rtl/arb_pri_sampler.sv
module arb_pri_sampler #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pri_req_n,
   output logic pri_now,
   output logic pri_seen
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 1) begin : g_bad
      $error("arb_pri_sampler: STAGES must be at least 1");
   end

   logic [LAST:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= ~pri_req_n;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[i] <= 1'b0;
         else        chain_q[i] <= chain_q[i-1];
      end
   end

   if (STAGES == 1) begin : g_direct
      assign pri_now = ~pri_req_n;
   end else begin : g_delayed
      assign pri_now = chain_q[LAST-1];
   end

   assign pri_seen = chain_q[LAST];
endmodule

// File: rtl/arb_lock_trk.sv
module arb_lock_trk #(
   parameter bit LOCK_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_start,
   input  logic lock_end,
   input  logic may_start,
   input  logic pri_seen,
   output logic lock_q
);
   if (LOCK_EN) begin : g_lock
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        lock_q <= 1'b0;
         else if (lock_end)                 lock_q <= 1'b0;
         else if (lock_start && may_start)  lock_q <= 1'b1;
      end

      p_no_lock_under_pri_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (pri_seen && !lock_q) |=> !lock_q);
      p_lock_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
         lock_end |=> !lock_q);
   end else begin : g_nolock
      logic lock_unused;
      assign lock_unused = lock_start ^ lock_end ^ may_start ^ pri_seen;
      assign lock_q = 1'b0;
   end
endmodule

// File: rtl/arb_out_ctr.sv
module arb_out_ctr #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   if (CNT_W < 1) begin : g_bad
      $error("arb_out_ctr: CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (inc && !dec && cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
      else if (dec && !inc && cnt != '0)      cnt <= cnt - CNT_ONE;
   end

   p_cnt_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && cnt != CNT_MAX) |=> cnt == $past(cnt) + CNT_ONE);
   p_cnt_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && cnt != '0) |=> cnt == $past(cnt) - CNT_ONE);
   p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc == dec) |=> $stable(cnt));
endmodule

// File: rtl/prio_bus_arb.sv
module prio_bus_arb #(
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 1,
   parameter bit LOCK_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_req_n,
   input  logic             pri_req_n,
   input  logic             lock_start,
   input  logic             lock_end,
   input  logic             pri_issue,
   input  logic             pri_done,
   output logic             sym_issue_en,
   output logic [1:0]       owner,
   output logic             lock_active,
   output logic [CNT_W-1:0] pri_outstanding
);
   import arb_pkg::*;

   own_e own_q, own_d;
   logic pri_now, pri_seen, lock_q, may_start, lock_holds;

   arb_pri_sampler #(.STAGES(SYNC_STAGES)) u_samp (
      .clk(clk), .rst_n(rst_n), .pri_req_n(pri_req_n),
      .pri_now(pri_now), .pri_seen(pri_seen));

   assign may_start = (own_q == OWN_SYM) && !pri_seen && !pri_now;

   arb_lock_trk #(.LOCK_EN(LOCK_EN)) u_lock (
      .clk(clk), .rst_n(rst_n), .lock_start(lock_start), .lock_end(lock_end),
      .may_start(may_start), .pri_seen(pri_seen), .lock_q(lock_q));

   arb_out_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc(pri_issue), .dec(pri_done),
      .cnt(pri_outstanding));

   assign lock_holds = lock_q && !lock_end && (own_q == OWN_SYM);

   always_comb begin
      if (lock_holds)     own_d = OWN_SYM;
      else if (pri_now)   own_d = OWN_PRI;
      else if (!sym_req_n) own_d = OWN_SYM;
      else                own_d = OWN_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) own_q <= OWN_NONE;
      else        own_q <= own_d;
   end

   assign owner        = own_q;
   assign lock_active  = lock_q;
   assign sym_issue_en = (own_q == OWN_SYM) && (!pri_seen || lock_q);

   p_preempt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_now && !lock_q) |=> owner == OWN_PRI);
   p_issue_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == OWN_PRI) |-> !sym_issue_en);
   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pri_now && !sym_req_n) |=> owner == OWN_SYM);
   p_owner_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owner));
endmodule

// File: tb/sim_prio_bus_arb.sv
`timescale 1ns/1ps
module sim_prio_bus_arb;
   localparam int CNT_W = 4;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sym_req_n = 1'b1, pri_req_n = 1'b1;
   logic lock_start = 1'b0, lock_end = 1'b0, pri_issue = 1'b0, pri_done = 1'b0;
   logic sym_issue_en, lock_active;
   logic [1:0] owner;
   logic [CNT_W-1:0] pri_outstanding;
   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   prio_bus_arb #(.CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .sym_req_n(sym_req_n), .pri_req_n(pri_req_n),
      .lock_start(lock_start), .lock_end(lock_end), .pri_issue(pri_issue),
      .pri_done(pri_done), .sym_issue_en(sym_issue_en), .owner(owner),
      .lock_active(lock_active), .pri_outstanding(pri_outstanding));

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic t_reset();
      chk("R1 owner", owner, 0);
      chk("R1 issue_en", sym_issue_en, 0);
      chk("R1 lock", lock_active, 0);
      chk("R1 count", pri_outstanding, 0);
   endtask

   task automatic t_idle();
      sym_req_n = 1'b1; pri_req_n = 1'b1; tick();
      chk("R9 owner", owner, 0);
      chk("R9 issue_en", sym_issue_en, 0);
      lock_start = 1'b1; tick(); lock_start = 1'b0;
      chk("R10 lock ignored with no owner", lock_active, 0);
   endtask

   task automatic t_grant();
      sym_req_n = 1'b0; tick();
      chk("R2 owner", owner, 1);
      chk("R2 issue_en", sym_issue_en, 1);
   endtask

   task automatic t_preempt_count();
      pri_req_n = 1'b0; tick();
      chk("R3 owner", owner, 2);
      chk("R3 issue_en", sym_issue_en, 0);
      pri_issue = 1'b1;
      for (int i = 0; i < 3; i++) tick();
      pri_issue = 1'b0;
      chk("R7 count up", pri_outstanding, 3);
      pri_issue = 1'b1; pri_done = 1'b1; tick();
      chk("R7 both hold", pri_outstanding, 3);
      pri_issue = 1'b0;
      tick();
      chk("R7 count down", pri_outstanding, 2);
      tick(); tick(); tick();
      pri_done = 1'b0;
      chk("R7 floor", pri_outstanding, 0);
      pri_issue = 1'b1;
      for (int i = 0; i < CMAX + 3; i++) tick();
      pri_issue = 1'b0;
      chk("R7 ceiling", pri_outstanding, CMAX);
      pri_done = 1'b1;
      for (int i = 0; i < CMAX; i++) tick();
      pri_done = 1'b0;
      chk("R7 drained", pri_outstanding, 0);
      lock_start = 1'b1; tick(); lock_start = 1'b0;
      chk("R5 lock refused under priority", lock_active, 0);
      pri_req_n = 1'b1; tick();
      chk("R8 owner", owner, 1);
      chk("R8 issue_en", sym_issue_en, 1);
   endtask

   task automatic t_lock();
      lock_start = 1'b1; tick(); lock_start = 1'b0;
      chk("R6 lock set", lock_active, 1);
      pri_req_n = 1'b0; tick();
      chk("R4 owner kept", owner, 1);
      chk("R4 issue_en kept", sym_issue_en, 1);
      tick();
      chk("R4 still kept", owner, 1);
      lock_end = 1'b1; tick(); lock_end = 1'b0;
      chk("R4 lock cleared", lock_active, 0);
      chk("R4 owner handed", owner, 2);
      chk("R4 issue_en dropped", sym_issue_en, 0);
      pri_req_n = 1'b1; tick();
      chk("R8 return after lock", owner, 1);
      lock_start = 1'b1; tick(); lock_start = 1'b0;
      chk("R6 lock set again", lock_active, 1);
      lock_end = 1'b1; tick(); lock_end = 1'b0;
      chk("R6 lock end", lock_active, 0);
      sym_req_n = 1'b1; tick();
      chk("R9 back to none", owner, 0);
   endtask

   initial begin
      #1;
      t_reset();
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_idle();
      t_grant();
      t_preempt_count();
      t_lock();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0 (run hung)");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule